// File: doc/BRIEF.md
# Stepped Byte-Wide Processor Core

This block is a very small 8-bit processor core. It has a 16-bit address bus, an 8-bit data bus and a write strobe, and it performs exactly one bus access on every clock. Its architectural state is an accumulator, two index registers (X and Y), an 8-bit stack pointer, a status byte, a 16-bit program counter and an opcode register. A one-hot step register walks each instruction through numbered cycles T1 to T5. Each instruction produces a fixed address pattern on the bus, dummy cycles included.

The core handles eight opcodes:
- immediate loads of A, X and Y;
- absolute load and absolute store of A;
- push A;
- pull status;
- copy X into the stack pointer.

Out of reset it reads a little-endian start address from a vector pair and begins fetching there. Any other opcode stops the core: a sticky halt output is raised and the bus is frozen until the next reset.

The memory next to the core must return read data in the same cycle the address is presented, and it must commit a write at the clock edge that ends the write cycle. The register outputs expose the architectural state for observation.

Top module: `stepcore_top`

## Requirements
- R1: The step output is always one-hot, with bit 0 meaning T1. A cycle that does not end an instruction shifts it left by one, and the cycle that ends an instruction returns it to T1.
- R2: In T1 the byte read at the program counter becomes the opcode, the program counter advances by one, and the next cycle reads at the new program counter.
- R3: While reset is high, all registers are zero, the halt output is low, the step is T1, and the bus reads address 0xFFFC. After release the core reads 0xFFFC (low byte) and then 0xFFFD (high byte), and fetches its first opcode at the address they form.
- R4: Opcodes 0xA9, 0xA2 and 0xA0 load A, X and Y from the byte after the opcode. Each finishes in T2, and the next fetch is at the opcode address plus 2.
- R5: Opcode 0x9A copies X into the stack pointer. It finishes in T2, and the next fetch is at the opcode address plus 1.
- R6: Opcode 0xAD reads a low address byte and then a high address byte. In T4 it reads at {high, low} and loads A from that byte. The next fetch is at the opcode address plus 3.
- R7: Opcode 0x8D takes its operand bytes the same way as R6, then writes A to {high, low} in T4. The next fetch is at the opcode address plus 3.
- R8: Opcode 0x48 re-reads the byte after the opcode in T2 and T3. In T4 it writes A to 0x0100 plus the stack pointer, and the stack pointer is then one lower, wrapping modulo 256. The next fetch is at the opcode address plus 1.
- R9: Opcode 0x28 re-reads the byte after the opcode in T2 and T3. In T4 it reads 0x0100 plus the stack pointer. In T5 it reads 0x0100 plus the stack pointer plus one (modulo 256) and loads the status byte from that read. The stack pointer ends one higher.
- R10: The status byte changes only at the end of T5 of opcode 0x28. Loads, stores and pushes leave it unchanged.
- R11: Any other opcode raises the halt output at the end of T2. The address, write strobe and step then stay frozen until reset, and reset clears the halt output.
- R12: Every clock carries exactly one bus access. The write strobe is high only in T4 of opcodes 0x8D and 0x48, and in that cycle the write data equals A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_din | input | 8 | Read data for the access on the bus this cycle |
| mem_addr | output | 16 | Address of the access this cycle |
| mem_we | output | 1 | High for a write, low for a read |
| mem_dout | output | 8 | Write data |
| halted | output | 1 | Sticky halt after an undefined opcode |
| step_o | output | 5 | One-hot step, bit 0 = T1 |
| acc_o | output | 8 | Accumulator |
| xr_o | output | 8 | X register |
| yr_o | output | 8 | Y register |
| sp_o | output | 8 | Stack pointer |
| psr_o | output | 8 | Status byte |

## Verification
The hardest states to reach from the ports are the stack-pointer wrap in both directions and a pull that must pick up a byte written earlier by a push. No stack pointer can be loaded directly. The stimulus therefore loads X with 0xFF and copies it to the stack pointer, so the next pull reads 0x01FF and then 0x0100. A push then writes 0x0100 and wraps the pointer back to 0xFF. A cycle-by-cycle bus trace of a mixed program checks the push-then-pull round trip. It also runs into an undefined opcode, to show that the bus stays frozen and that a later reset releases the halt.

// File: rtl/stepcore_pkg.sv
package stepcore_pkg;

    localparam int SC_STEPS = 5;
    localparam int SC_AW    = 16;
    localparam int SC_DW    = 8;

    typedef logic [SC_STEPS-1:0] step_t;
    typedef logic [SC_AW-1:0]    addr_t;
    typedef logic [SC_DW-1:0]    byte_t;

    localparam step_t STEP_FIRST = step_t'(1);

    typedef enum logic [3:0] {
        IC_LOAD_A_IMM,
        IC_LOAD_X_IMM,
        IC_LOAD_Y_IMM,
        IC_X_TO_SP,
        IC_LOAD_A_ABS,
        IC_STORE_A_ABS,
        IC_PUSH_A,
        IC_PULL_ST,
        IC_UNDEF
    } icls_e;

    typedef enum logic [1:0] {
        BOOT_LO,
        BOOT_HI,
        BOOT_RUN
    } boot_e;

    typedef enum logic [2:0] {
        AS_HOLD,
        AS_PC,
        AS_PC_NEXT,
        AS_ABS,
        AS_STACK,
        AS_VEC_HI
    } asrc_e;

    typedef enum logic [1:0] {
        PC_KEEP,
        PC_INC,
        PC_LOAD
    } pcop_e;

    typedef enum logic [2:0] {
        DST_NONE,
        DST_IR,
        DST_A,
        DST_X,
        DST_Y,
        DST_P
    } dst_e;

    typedef enum logic [1:0] {
        SP_KEEP,
        SP_INC,
        SP_DEC,
        SP_FROM_X
    } spop_e;

    typedef struct packed {
        asrc_e asrc;
        logic  wr;
        pcop_e pc_op;
        dst_e  dst;
        spop_e sp_op;
        logic  lo_ld;
        logic  fin;
        logic  bad;
    } uop_t;

    function automatic uop_t uop_idle();
        uop_t u;
        u.asrc  = AS_HOLD;
        u.wr    = 1'b0;
        u.pc_op = PC_KEEP;
        u.dst   = DST_NONE;
        u.sp_op = SP_KEEP;
        u.lo_ld = 1'b0;
        u.fin   = 1'b0;
        u.bad   = 1'b0;
        return u;
    endfunction

    function automatic addr_t join_bytes(byte_t hi, byte_t lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import stepcore_pkg::*;
(
    input  byte_t ir,
    output icls_e cls
);
    always_comb begin
        unique case (ir)
            8'hA9:   cls = IC_LOAD_A_IMM;
            8'hA2:   cls = IC_LOAD_X_IMM;
            8'hA0:   cls = IC_LOAD_Y_IMM;
            8'h9A:   cls = IC_X_TO_SP;
            8'hAD:   cls = IC_LOAD_A_ABS;
            8'h8D:   cls = IC_STORE_A_ABS;
            8'h48:   cls = IC_PUSH_A;
            8'h28:   cls = IC_PULL_ST;
            default: cls = IC_UNDEF;
        endcase
    end
endmodule

// File: rtl/sc_stepper.sv
module sc_stepper
    import stepcore_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fin,
    input  logic  bad,
    output boot_e boot,
    output step_t step,
    output logic  halted
);
    always_ff @(posedge clk) begin
        if (rst) begin
            boot   <= BOOT_LO;
            step   <= STEP_FIRST;
            halted <= 1'b0;
        end else if (!halted) begin
            unique case (boot)
                BOOT_LO: boot <= BOOT_HI;
                BOOT_HI: boot <= BOOT_RUN;
                default: begin
                    if (bad)      halted <= 1'b1;
                    else if (fin) step   <= STEP_FIRST;
                    else          step   <= step << 1;
                end
            endcase
        end
    end

    AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(step) == 1);                                            // R1
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (boot == BOOT_RUN && !halted && !fin && !bad) |=> step == ($past(step) << 1)); // R1
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(step));                               // R11
endmodule

// File: rtl/sc_microcode.sv
module sc_microcode
    import stepcore_pkg::*;
(
    input  boot_e boot,
    input  step_t step,
    input  icls_e cls,
    input  logic  halted,
    output uop_t  u
);
    always_comb begin
        u = uop_idle();
        if (!halted) begin
            unique case (boot)
                BOOT_LO: begin
                    u.lo_ld = 1'b1;
                    u.asrc  = AS_VEC_HI;
                end
                BOOT_HI: begin
                    u.pc_op = PC_LOAD;
                    u.asrc  = AS_ABS;
                end
                default: begin
                    if (step[0]) begin
                        u.dst   = DST_IR;
                        u.pc_op = PC_INC;
                        u.asrc  = AS_PC_NEXT;
                    end else if (step[1]) begin
                        unique case (cls)
                            IC_LOAD_A_IMM, IC_LOAD_X_IMM, IC_LOAD_Y_IMM: begin
                                u.dst   = (cls == IC_LOAD_A_IMM) ? DST_A :
                                          (cls == IC_LOAD_X_IMM) ? DST_X : DST_Y;
                                u.pc_op = PC_INC;
                                u.asrc  = AS_PC_NEXT;
                                u.fin   = 1'b1;
                            end
                            IC_X_TO_SP: begin
                                u.sp_op = SP_FROM_X;
                                u.asrc  = AS_PC;
                                u.fin   = 1'b1;
                            end
                            IC_LOAD_A_ABS, IC_STORE_A_ABS: begin
                                u.lo_ld = 1'b1;
                                u.pc_op = PC_INC;
                                u.asrc  = AS_PC_NEXT;
                            end
                            IC_PUSH_A, IC_PULL_ST: u.asrc = AS_HOLD;
                            default: u.bad = 1'b1;
                        endcase
                    end else if (step[2]) begin
                        unique case (cls)
                            IC_LOAD_A_ABS, IC_STORE_A_ABS: begin
                                u.pc_op = PC_INC;
                                u.asrc  = AS_ABS;
                                u.wr    = (cls == IC_STORE_A_ABS);
                            end
                            IC_PUSH_A: begin
                                u.asrc  = AS_STACK;
                                u.wr    = 1'b1;
                                u.sp_op = SP_DEC;
                            end
                            IC_PULL_ST: begin
                                u.asrc  = AS_STACK;
                                u.sp_op = SP_INC;
                            end
                            default: begin
                                u.asrc = AS_PC;
                                u.fin  = 1'b1;
                            end
                        endcase
                    end else if (step[3]) begin
                        unique case (cls)
                            IC_LOAD_A_ABS: begin
                                u.dst  = DST_A;
                                u.asrc = AS_PC;
                                u.fin  = 1'b1;
                            end
                            IC_PULL_ST: u.asrc = AS_STACK;
                            default: begin
                                u.asrc = AS_PC;
                                u.fin  = 1'b1;
                            end
                        endcase
                    end else begin
                        if (cls == IC_PULL_ST) u.dst = DST_P;
                        u.asrc = AS_PC;
                        u.fin  = 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
    import stepcore_pkg::*;
#(
    parameter addr_t VEC_ADDR   = 16'hFFFC,
    parameter byte_t STACK_PAGE = 8'h01
)(
    input  logic  clk,
    input  logic  rst,
    input  uop_t  u,
    input  byte_t din,
    output addr_t addr,
    output logic  we,
    output byte_t dout,
    output byte_t a,
    output byte_t x,
    output byte_t y,
    output byte_t sp,
    output byte_t p,
    output byte_t ir
);
    addr_t pc;
    byte_t lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= '0;
            lo   <= '0;
            a    <= '0;
            x    <= '0;
            y    <= '0;
            sp   <= '0;
            p    <= '0;
            ir   <= '0;
            addr <= VEC_ADDR;
            we   <= 1'b0;
            dout <= '0;
        end else begin
            if (u.lo_ld) lo <= din;

            unique case (u.pc_op)
                PC_INC:  pc <= pc + addr_t'(1);
                PC_LOAD: pc <= join_bytes(din, lo);
                default: ;
            endcase

            unique case (u.dst)
                DST_IR:  ir <= din;
                DST_A:   a  <= din;
                DST_X:   x  <= din;
                DST_Y:   y  <= din;
                DST_P:   p  <= din;
                default: ;
            endcase

            unique case (u.sp_op)
                SP_INC:    sp <= sp + byte_t'(1);
                SP_DEC:    sp <= sp - byte_t'(1);
                SP_FROM_X: sp <= x;
                default:   ;
            endcase

            if (u.asrc != AS_HOLD) begin
                we <= u.wr;
                if (u.wr) dout <= a;
            end
            unique case (u.asrc)
                AS_PC:      addr <= pc;
                AS_PC_NEXT: addr <= pc + addr_t'(1);
                AS_ABS:     addr <= join_bytes(din, lo);
                AS_STACK:   addr <= join_bytes(STACK_PAGE, sp);
                AS_VEC_HI:  addr <= VEC_ADDR + addr_t'(1);
                default:    ;
            endcase
        end
    end

    AST_WRITE_IS_ACC: assert property (@(posedge clk) disable iff (rst)
        we |-> dout == a);                                                 // R12
endmodule

// File: rtl/stepcore_top.sv
module stepcore_top
    import stepcore_pkg::*;
#(
    parameter logic [15:0] VEC_ADDR   = 16'hFFFC,
    parameter logic [7:0]  STACK_PAGE = 8'h01
)(
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    mem_din,
    output logic [15:0]   mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_dout,
    output logic          halted,
    output logic [4:0]    step_o,
    output logic [7:0]    acc_o,
    output logic [7:0]    xr_o,
    output logic [7:0]    yr_o,
    output logic [7:0]    sp_o,
    output logic [7:0]    psr_o
);
    boot_e boot;
    step_t step;
    icls_e cls;
    uop_t  u;
    byte_t ir;

    sc_decode u_dec (.ir(ir), .cls(cls));

    sc_stepper u_step (
        .clk(clk), .rst(rst), .fin(u.fin), .bad(u.bad),
        .boot(boot), .step(step), .halted(halted)
    );

    sc_microcode u_uc (
        .boot(boot), .step(step), .cls(cls), .halted(halted), .u(u)
    );

    sc_datapath #(.VEC_ADDR(VEC_ADDR), .STACK_PAGE(STACK_PAGE)) u_dp (
        .clk(clk), .rst(rst), .u(u), .din(mem_din),
        .addr(mem_addr), .we(mem_we), .dout(mem_dout),
        .a(acc_o), .x(xr_o), .y(yr_o), .sp(sp_o), .p(psr_o), .ir(ir)
    );

    assign step_o = step;

    AST_FETCH_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (step[0] && boot == BOOT_RUN && !halted) |=> (!mem_we && mem_addr == $past(mem_addr) + 16'd1)); // R2
    AST_PSR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step[4] |=> $stable(psr_o));                                      // R10
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(mem_addr) && $stable(mem_we)));                // R11
    AST_PUSH_STACK: assert property (@(posedge clk) disable iff (rst)
        (boot == BOOT_RUN && cls == IC_PUSH_A && step[3]) |-> (mem_we && mem_addr[15:8] == STACK_PAGE)); // R8
endmodule

// File: tb/sim_stepcore_top.sv
module sim_stepcore_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic [7:0]  mem_din;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_dout;
    logic        halted;
    logic [4:0]  step_o;
    logic [7:0]  acc_o, xr_o, yr_o, sp_o, psr_o;

    stepcore_top u0 (
        .clk(clk), .rst(rst), .mem_din(mem_din), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_dout(mem_dout), .halted(halted), .step_o(step_o),
        .acc_o(acc_o), .xr_o(xr_o), .yr_o(yr_o), .sp_o(sp_o), .psr_o(psr_o)
    );

    // 1 KiB memory model aliased on addr[9:0]; vector 0xFFFC sits at 0x3FC
    logic [7:0] mem [1024];
    logic       ld_en;
    logic [9:0] ld_a;
    logic [7:0] ld_d;
    assign mem_din = mem[mem_addr[9:0]];
    always @(posedge clk) begin
        if (ld_en)       mem[ld_a] <= ld_d;
        else if (mem_we) mem[mem_addr[9:0]] <= mem_dout;
    end

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [9:0] a, input logic [7:0] d);
        ld_en = 1'b1; ld_a = a; ld_d = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic clear_mem();
        for (int k = 0; k < 1024; k++) poke(10'(k), 8'h00);
    endtask

    task automatic check_reset_state();
        chk("R3", "reset addr",   mem_addr, 16'hFFFC);
        chk("R3", "reset we",     mem_we,   1'b0);
        chk("R3", "reset step",   step_o,   5'd1);
        chk("R11", "reset clears halt", halted, 1'b0);
        chk("R3", "reset regs",   {acc_o, xr_o, yr_o, sp_o}, 32'h0);
        chk("R3", "reset status", psr_o,    8'h00);
    endtask

    localparam logic [7:0] PROG1 [18] = '{
        8'hA2, 8'h80, 8'h9A, 8'hA9, 8'h5A, 8'h48, 8'hA0, 8'h33, 8'hA9,
        8'hC3, 8'h8D, 8'h34, 8'h12, 8'hAD, 8'h10, 8'h03, 8'h28, 8'hFF };

    // {halted, step[4:0], we, addr[15:0], dout[7:0]}
    localparam logic [30:0] TRACE [32] = '{
        {1'b0, 5'd1,  1'b0, 16'hFFFC, 8'h00},
        {1'b0, 5'd1,  1'b0, 16'hFFFD, 8'h00},
        {1'b0, 5'd1,  1'b0, 16'h0200, 8'h00},
        {1'b0, 5'd2,  1'b0, 16'h0201, 8'h00},
        {1'b0, 5'd1,  1'b0, 16'h0202, 8'h00},
        {1'b0, 5'd2,  1'b0, 16'h0203, 8'h00},
        {1'b0, 5'd1,  1'b0, 16'h0203, 8'h00},
        {1'b0, 5'd2,  1'b0, 16'h0204, 8'h00},
        {1'b0, 5'd1,  1'b0, 16'h0205, 8'h00},
        {1'b0, 5'd2,  1'b0, 16'h0206, 8'h00},
        {1'b0, 5'd4,  1'b0, 16'h0206, 8'h00},
        {1'b0, 5'd8,  1'b1, 16'h0180, 8'h5A},
        {1'b0, 5'd1,  1'b0, 16'h0206, 8'h00},
        {1'b0, 5'd2,  1'b0, 16'h0207, 8'h00},
        {1'b0, 5'd1,  1'b0, 16'h0208, 8'h00},
        {1'b0, 5'd2,  1'b0, 16'h0209, 8'h00},
        {1'b0, 5'd1,  1'b0, 16'h020A, 8'h00},
        {1'b0, 5'd2,  1'b0, 16'h020B, 8'h00},
        {1'b0, 5'd4,  1'b0, 16'h020C, 8'h00},
        {1'b0, 5'd8,  1'b1, 16'h1234, 8'hC3},
        {1'b0, 5'd1,  1'b0, 16'h020D, 8'h00},
        {1'b0, 5'd2,  1'b0, 16'h020E, 8'h00},
        {1'b0, 5'd4,  1'b0, 16'h020F, 8'h00},
        {1'b0, 5'd8,  1'b0, 16'h0310, 8'h00},
        {1'b0, 5'd1,  1'b0, 16'h0210, 8'h00},
        {1'b0, 5'd2,  1'b0, 16'h0211, 8'h00},
        {1'b0, 5'd4,  1'b0, 16'h0211, 8'h00},
        {1'b0, 5'd8,  1'b0, 16'h017F, 8'h00},
        {1'b0, 5'd16, 1'b0, 16'h0180, 8'h00},
        {1'b0, 5'd1,  1'b0, 16'h0211, 8'h00},
        {1'b0, 5'd2,  1'b0, 16'h0212, 8'h00},
        {1'b1, 5'd2,  1'b0, 16'h0212, 8'h00} };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; ld_en = 1'b0; ld_a = '0; ld_d = '0;
        @(negedge clk);
        clear_mem();
        poke(10'h3FC, 8'h00);
        poke(10'h3FD, 8'h02);
        for (int k = 0; k < 18; k++) poke(10'h200 + 10'(k), PROG1[k]);
        poke(10'h310, 8'h77);
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;

        for (int i = 0; i < 32; i++) begin
            logic [30:0] e;
            e = TRACE[i];
            chk("R1",  $sformatf("step c%0d", i),  step_o,   e[29:25]);
            chk("R12", $sformatf("addr c%0d", i),  mem_addr, e[23:8]);
            chk("R12", $sformatf("we c%0d", i),    mem_we,   e[24]);
            chk("R11", $sformatf("halt c%0d", i),  halted,   e[30]);
            if (e[24]) chk("R12", $sformatf("dout c%0d", i), mem_dout, e[7:0]);
            chk("R10", $sformatf("status c%0d", i), psr_o, (i >= 29) ? 8'h5A : 8'h00);
            case (i)
                4:  chk("R4", "X after immediate load", xr_o, 8'h80);
                6:  chk("R5", "sp copied from X", sp_o, 8'h80);
                8:  chk("R4", "A after immediate load", acc_o, 8'h5A);
                12: chk("R8", "sp after push", sp_o, 8'h7F);
                14: chk("R4", "Y after immediate load", yr_o, 8'h33);
                24: chk("R6", "A after absolute load", acc_o, 8'h77);
                28: chk("R9", "sp after pull", sp_o, 8'h80);
                default: ;
            endcase
            @(negedge clk);
        end

        repeat (20) @(negedge clk);
        chk("R11", "halt sticky",    halted,   1'b1);
        chk("R11", "addr frozen",    mem_addr, 16'h0212);
        chk("R11", "we frozen",      mem_we,   1'b0);
        chk("R11", "step frozen",    step_o,   5'd2);
        chk("R7",  "stored byte",    mem[10'h234], 8'hC3);
        chk("R8",  "pushed byte",    mem[10'h180], 8'h5A);
        chk("R9",  "status from stack", psr_o, 8'h5A);
        chk("R6",  "final A",        acc_o,    8'h77);

        // Second run: vector 0x0240, stack wrap both ways, reset clears halt
        rst = 1'b1;
        @(negedge clk);
        clear_mem();
        poke(10'h3FC, 8'h40);
        poke(10'h3FD, 8'h02);
        poke(10'h240, 8'hA2); poke(10'h241, 8'hFF);
        poke(10'h242, 8'h9A); poke(10'h243, 8'h28);
        poke(10'h244, 8'h48); poke(10'h245, 8'hFF);
        poke(10'h1FF, 8'h11); poke(10'h100, 8'hE7);
        check_reset_state();
        rst = 1'b0;
        chk("R3", "vector low read", mem_addr, 16'hFFFC);
        @(negedge clk);
        chk("R3", "vector high read", mem_addr, 16'hFFFD);
        @(negedge clk);
        chk("R3", "first fetch at vector", mem_addr, 16'h0240);
        for (int k = 0; k < 40 && !halted; k++) @(negedge clk);
        chk("R11", "second run halts",     halted,   1'b1);
        chk("R9",  "status after wrap",    psr_o,    8'hE7);
        chk("R8",  "sp wraps down",        sp_o,     8'hFF);
        chk("R8",  "push at 0x0100",       mem[10'h100], 8'h00);
        chk("R9",  "low stack byte kept",  mem[10'h1FF], 8'h11);
        chk("R11", "halted addr",          mem_addr, 16'h0246);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule